// File: doc/BRIEF.md
# Split-Write DAC Code Loader

This block lets a host with an 8-bit write bus set a 12-bit converter code without the converter ever seeing a half-updated value. The host first writes the low nibble. That value is kept in a staging register and does not reach the output. The host then writes the upper byte. On the clock edge that accepts the upper byte, the full word is formed from the new byte and the staged nibble, and it is placed on the converter inputs in a single step.

The output is a registered 12-bit code together with a one-cycle load strobe that the converter interface can use as its latch enable. The widths, the two register offsets and the address width are parameters. They are checked at elaboration.

Top module: `dacw_split_writer`

## Requirements
- R1: After reset, `dac_code` is 000h, `dac_load` is 0 and the staged nibble is 0. A first upper-byte write therefore produces `{byte, 0h}`.
- R2: A write to offset 4 stores only `wr_data[3:0]` as the staged nibble. Bits 7:4 of that write are ignored.
- R3: A write to offset 4 leaves `dac_code` unchanged and does not assert `dac_load`.
- R4: A write to offset 5 sets `dac_code` to `{wr_data[7:0], staged nibble}` (byte in bits 11:4, nibble in bits 3:0) on the clock edge that accepts the write.
- R5: `dac_load` is high for exactly the cycle after each accepted offset-5 write, which is the cycle in which the new code first appears. It is low in every other cycle.
- R6: Moving from 1AFh to 1B0h with a low write (0h) followed by a high write (1Bh) shows only 1AFh and then 1B0h on `dac_code`. No intermediate value such as 1A0h or 1BFh ever appears.
- R7: An offset-5 write with no offset-4 write since the previous one reuses the nibble staged last.
- R8: Writes to any offset other than 4 or 5 change neither `dac_code`, `dac_load` nor the staged nibble.
- R9: `dac_code` holds its value in every cycle where `dac_load` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_addr | input | 3 | Register offset of the write |
| wr_data | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| dac_code | output | 12 | Registered code driven to the converter |
| dac_load | output | 1 | One-cycle pulse marking a new code |

## Verification
The staged nibble has no port of its own. The only way to see it is through the code that a later upper-byte write produces. The directed scenarios therefore always close with an offset-5 write: after reset to expose the cleared nibble, after writes to unused offsets to show that the nibble survived them, and twice in a row to show that it is reused. The 1AFh to 1B0h step is checked by sampling `dac_code` in every cycle of the sequence, so that any intermediate value would be caught.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

   // Kind of host access seen by the decoder in a given cycle.
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_LO   = 2'd1,
      ACC_HI   = 2'd2
   } dacw_access_e;

endpackage

// File: rtl/dacw_decode.sv
module dacw_decode
   import dacw_pkg::*;
#(
   parameter int ADDR_W  = 3,
   parameter int LO_ADDR = 4,
   parameter int HI_ADDR = 5
) (
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_en,
   output dacw_access_e      access
);

   localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);
   localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);

   always_comb begin
      access = ACC_NONE;
      if (wr_en) begin
         if (wr_addr == LO_A)      access = ACC_LO;
         else if (wr_addr == HI_A) access = ACC_HI;
      end
   end

endmodule

// File: rtl/dacw_stage.sv
module dacw_stage
   import dacw_pkg::*;
#(
   parameter int LO_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  dacw_access_e    access,
   input  logic [LO_W-1:0] lo_in,
   output logic [LO_W-1:0] lo_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lo_q <= '0;
      else if (access == ACC_LO)
         lo_q <= lo_in;
   end

   // R8: only a low access may touch the staged nibble
   p_nibble_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (access != ACC_LO) |=> $stable(lo_q));

endmodule

// File: rtl/dacw_commit.sv
module dacw_commit
   import dacw_pkg::*;
#(
   parameter int DAC_W = 12,
   parameter int LO_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dacw_access_e      access,
   input  logic [DAC_W-LO_W-1:0] hi_in,
   input  logic [LO_W-1:0]   lo_in,
   output logic [DAC_W-1:0]  code_q,
   output logic              load_q
);

   localparam int HI_W = DAC_W - LO_W;

   logic take;
   assign take = (access == ACC_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         load_q <= 1'b0;
      end else begin
         load_q <= take;
         if (take)
            code_q <= {hi_in, lo_in};
      end
   end

   // R4: the upper field reflects the byte accepted one edge earlier
   p_hi_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (code_q[DAC_W-1:LO_W] == $past(hi_in)));

   // R5: strobe follows an upper write
   p_load_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> load_q);

   // R5: no strobe without an upper write
   p_load_only_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> !load_q);

   // R9: the code moves only together with the strobe
   p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load_q |-> $stable(code_q));

   initial begin
      if (HI_W < 1) $error("dacw_commit: upper field must be non-empty");
   end

endmodule

// File: rtl/dacw_split_writer.sv
module dacw_split_writer
   import dacw_pkg::*;
#(
   parameter int DAC_W   = 12,
   parameter int BUS_W   = 8,
   parameter int ADDR_W  = 3,
   parameter int LO_ADDR = 4,
   parameter int HI_ADDR = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic              wr_en,
   output logic [DAC_W-1:0]  dac_code,
   output logic              dac_load
);

   localparam int LO_W = DAC_W - BUS_W;

   // Elaboration-time parameter checks
   if (LO_W < 1 || LO_W > BUS_W) begin : g_bad_width
      $error("dacw_split_writer: DAC_W must lie in (BUS_W, 2*BUS_W]");
   end
   if (LO_ADDR == HI_ADDR) begin : g_bad_addr
      $error("dacw_split_writer: low and high offsets must differ");
   end
   if (HI_ADDR >= (1 << ADDR_W) || LO_ADDR >= (1 << ADDR_W)) begin : g_bad_span
      $error("dacw_split_writer: offsets exceed address width");
   end

   dacw_access_e    access;
   logic [LO_W-1:0] lo_q;

   dacw_decode #(
      .ADDR_W (ADDR_W),
      .LO_ADDR(LO_ADDR),
      .HI_ADDR(HI_ADDR)
   ) u_decode (
      .wr_addr(wr_addr),
      .wr_en  (wr_en),
      .access (access)
   );

   dacw_stage #(
      .LO_W(LO_W)
   ) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .access(access),
      .lo_in (wr_data[LO_W-1:0]),
      .lo_q  (lo_q)
   );

   dacw_commit #(
      .DAC_W(DAC_W),
      .LO_W (LO_W)
   ) u_commit (
      .clk   (clk),
      .rst_n (rst_n),
      .access(access),
      .hi_in (wr_data),
      .lo_in (lo_q),
      .code_q(dac_code),
      .load_q(dac_load)
   );

   // R3: a low write never produces a strobe
   p_lo_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(LO_ADDR)) |=> !dac_load);

   // R4/R7: the low field of a new code is the nibble staged beforehand
   p_lo_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(HI_ADDR)) |=> (dac_code[LO_W-1:0] == $past(lo_q)));

endmodule

// File: tb/dacw_split_writer_test.sv
module dacw_split_writer_test;

   localparam int PERIOD = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        wr_en = 1'b0;
   logic [11:0] dac_code;
   logic        dac_load;

   int checks = 0;
   int errors = 0;

   always #(PERIOD/2) clk = ~clk;

   dacw_split_writer uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .wr_en   (wr_en),
      .dac_code(dac_code),
      .dac_load(dac_load)
   );

   task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %03h expected %03h", req, act, exp);
      end
   endtask

   // One write; returns at the negedge after the accepting edge.
   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 code", dac_code, 12'h000);
      check("R1 load", {11'd0, dac_load}, 12'd0);
      bus_write(3'd5, 8'hA5);
      check("R1 nibble cleared", dac_code, 12'hA50);
      check("R5 load high", {11'd0, dac_load}, 12'd1);
      @(negedge clk);
      check("R5 load single cycle", {11'd0, dac_load}, 12'd0);
   endtask

   task automatic t_low_then_high();
      bus_write(3'd4, 8'hF3);
      check("R3 code kept", dac_code, 12'hA50);
      check("R3 no load", {11'd0, dac_load}, 12'd0);
      bus_write(3'd5, 8'h12);
      check("R2 upper bits ignored", dac_code, 12'h123);
      check("R4 load with code", {11'd0, dac_load}, 12'd1);
   endtask

   task automatic t_glitch_free();
      bus_write(3'd4, 8'h0F);
      bus_write(3'd5, 8'h1A);
      check("R6 start", dac_code, 12'h1AF);
      @(negedge clk);
      wr_addr = 3'd4; wr_data = 8'h00; wr_en = 1'b1;
      @(negedge clk);
      check("R6 after low", dac_code, 12'h1AF);
      wr_addr = 3'd5; wr_data = 8'h1B;
      @(negedge clk);
      wr_en = 1'b0;
      check("R6 final", dac_code, 12'h1B0);
      @(negedge clk);
      check("R9 hold", dac_code, 12'h1B0);
   endtask

   task automatic t_reuse();
      bus_write(3'd4, 8'h09);
      bus_write(3'd5, 8'h31);
      check("R7 first", dac_code, 12'h319);
      bus_write(3'd5, 8'h2C);
      check("R7 reuse", dac_code, 12'h2C9);
   endtask

   task automatic t_other();
      for (int a = 0; a < 8; a++) begin
         if (a != 4 && a != 5) begin
            bus_write(3'(a), 8'hF6);
            check("R8 code", dac_code, 12'h2C9);
            check("R8 load", {11'd0, dac_load}, 12'd0);
         end
      end
      bus_write(3'd5, 8'h00);
      check("R8 nibble intact", dac_code, 12'h009);
   endtask

   task automatic t_back_to_back();
      @(negedge clk);
      wr_addr = 3'd5; wr_data = 8'h44; wr_en = 1'b1;
      @(negedge clk);
      check("R4 b2b first", dac_code, 12'h449);
      wr_data = 8'h55;
      @(negedge clk);
      wr_en = 1'b0;
      check("R4 b2b second", dac_code, 12'h559);
      check("R5 b2b load", {11'd0, dac_load}, 12'd1);
      @(negedge clk);
      check("R5 b2b drop", {11'd0, dac_load}, 12'd0);
   endtask

   initial begin
      #(PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_low_then_high();
      t_glitch_free();
      t_reuse();
      t_other();
      t_back_to_back();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule